// File: doc/BRIEF.md
# SCL Phase Generator

This block turns a 32-bit divider word into the SCL waveform of an I2C master and into four single-cycle strobes that the byte engine uses to place its SDA activity. The lower half of the divider word sets how long SCL stays low. The upper half sets how long it stays high. Each unit in either half stands for eight input clocks. One full SCL period is therefore 8 × (low + high) clocks, and a symmetric setting of h in both halves gives SCL = clk / (16 × h). Software that targets a rate, 100 kHz by default and at most 400 kHz, computes the half value rounded up, so the produced rate never exceeds the target.

While enabled, the generator starts with SCL high for one full high phase. This phase is where the engine places a START. The generator then alternates low and high phases. In the middle of each low phase it pulses a drive strobe, at which the engine changes SDA. In the middle of each high phase it pulses a sample strobe, at which the engine reads SDA or places a START or STOP. It also pulses rise and fall strobes in the same cycle that SCL changes. While disabled, SCL rests high and all strobes stay quiet.

Top module: `scl_phase_gen`

## Requirements
- R1: The low phase lasts 8 × div_cfg[15:0] clocks and the high phase lasts 8 × div_cfg[31:16] clocks.
- R2: With equal halves h, the SCL period is 16 × h clocks and the waveform is symmetric.
- R3: On the first clock edge that sees en high after a disabled cycle, a high phase begins with SCL held high. The first fall of SCL is seen exactly 8 × high clocks after that edge.
- R4: sda_drive_stb is high for one cycle per low phase, (L/2 − 1) cycles after the fall strobe, where L is the low-phase length in clocks. SCL is low whenever it is high.
- R5: sda_sample_stb is high for one cycle per high phase, (H/2 − 1) cycles after the phase begins, where H is the high-phase length in clocks. SCL is high whenever it is high.
- R6: scl_rise_stb and scl_fall_stb are single-cycle pulses in the very cycle that scl_o goes high or low because of a phase change.
- R7: A divider half of 0 acts as 1, so that phase lasts 8 clocks.
- R8: The divider word is taken at the start of each phase. A change in the middle of a phase takes effect from the next phase boundary.
- R9: While en is low, and from the cycle after en drops, scl_o is 1 and no strobe is high. Reset gives the same state.
- R10: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable from the master engine |
| div_cfg | input | 32 | [15:0] low-phase units, [31:16] high-phase units |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_drive_stb | output | 1 | Middle of the low phase: change SDA |
| sda_sample_stb | output | 1 | Middle of the high phase: sample SDA |
| scl_rise_stb | output | 1 | SCL rises this cycle |
| scl_fall_stb | output | 1 | SCL falls this cycle |

## Verification
Every result is counted in cycles from the edge that first sees en high, which is index 0. The first fall is due at index H and the next rise at H + L. The sample strobe is due at H/2 − 1 into each high phase and the drive strobe at L/2 − 1 after each fall. A divider change counts from the first phase that starts on or after the edge that samples the new word. The driver turns each case into a queue of expected strobes, each tagged with its index, together with the expected SCL level at each index. The monitor samples at the falling clock edge, so each registered output is read in the cycle it is due. The monitor flags a strobe that comes early, late, is missing, or is doubled, and it checks the idle state from the first cycle after en drops.

// File: rtl/scl_pg_pkg.sv
`timescale 1ns/1ps
package scl_pg_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  typedef struct packed {
    logic drive;
    logic sample;
    logic rise;
    logic fall;
  } strobe_t;
endpackage

// File: rtl/scl_pg_len.sv
`timescale 1ns/1ps
// Converts both divider halves into phase lengths in input clocks.
module scl_pg_len #(
  parameter int FIELD_W   = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int CNT_W    = FIELD_W + UNIT_LOG2
) (
  input  logic [2*FIELD_W-1:0]   div_cfg,
  output logic [1:0][CNT_W-1:0]  len_by_ph   // index = phase (0 low, 1 high)
);
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] eff;
    assign field = div_cfg[g*FIELD_W +: FIELD_W];
    // a zero field would stall the counter: treat it as one unit
    assign eff   = (field == '0) ? FIELD_W'(1) : field;
    assign len_by_ph[g] = CNT_W'(eff) << UNIT_LOG2;
  end
endmodule

// File: rtl/scl_pg_seq.sv
`timescale 1ns/1ps
// Phase state and the single reloading down-counter.
module scl_pg_seq
  import scl_pg_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [1:0][CNT_W-1:0] len_by_ph,
  output logic                  run_q,
  output phase_e                ph_q,
  output logic                  run_n,
  output phase_e                ph_n,
  output logic [CNT_W-1:0]      cnt_n,
  output logic [CNT_W-1:0]      len_n
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  always_comb begin
    run_n = en;
    ph_n  = ph_q;
    cnt_n = cnt_q;
    len_n = len_q;
    if (!en) begin
      ph_n  = PH_HIGH;
      cnt_n = '0;
    end else if (!run_q) begin
      // fresh start: a full high phase in which the engine may place START
      ph_n  = PH_HIGH;
      len_n = len_by_ph[1];
      cnt_n = len_n - CNT_W'(1);
    end else if (cnt_q == '0) begin
      ph_n  = phase_e'(~ph_q);
      len_n = len_by_ph[ph_n];
      cnt_n = len_n - CNT_W'(1);
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      run_q <= run_n;
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      len_q <= len_n;
    end
  end
endmodule

// File: rtl/scl_pg_out.sv
`timescale 1ns/1ps
// Registered SCL level and strobes, built from the next-state values so
// each strobe lines up with the SCL level it belongs to.
module scl_pg_out
  import scl_pg_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_q,
  input  phase_e           ph_q,
  input  logic             run_n,
  input  phase_e           ph_n,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic [CNT_W-1:0] len_n,
  output logic             scl_q,
  output strobe_t          stb_q
);
  logic [CNT_W-1:0] half_n;
  logic             mid_n;
  assign half_n = len_n >> 1;
  assign mid_n  = run_n && (cnt_n == half_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      stb_q <= '0;
    end else begin
      scl_q        <= !run_n || (ph_n == PH_HIGH);
      stb_q.rise   <= run_q && run_n && (ph_q == PH_LOW)  && (ph_n == PH_HIGH);
      stb_q.fall   <= run_q && run_n && (ph_q == PH_HIGH) && (ph_n == PH_LOW);
      stb_q.drive  <= mid_n && (ph_n == PH_LOW);
      stb_q.sample <= mid_n && (ph_n == PH_HIGH);
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen
  import scl_pg_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int UNIT_LOG2 = 3,   // clocks per divider unit = 2**UNIT_LOG2, at least 4
  localparam int CNT_W    = FIELD_W + UNIT_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2*FIELD_W-1:0] div_cfg,
  output logic                 scl_o,
  output logic                 sda_drive_stb,
  output logic                 sda_sample_stb,
  output logic                 scl_rise_stb,
  output logic                 scl_fall_stb
);
  logic [1:0][CNT_W-1:0] len_by_ph;
  logic                  run_q, run_n;
  phase_e                ph_q, ph_n;
  logic [CNT_W-1:0]      cnt_n, len_n;
  strobe_t               stb_q;

  scl_pg_len #(.FIELD_W(FIELD_W), .UNIT_LOG2(UNIT_LOG2)) u_len (
    .div_cfg  (div_cfg),
    .len_by_ph(len_by_ph)
  );

  scl_pg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .len_by_ph(len_by_ph),
    .run_q(run_q), .ph_q(ph_q), .run_n(run_n), .ph_n(ph_n),
    .cnt_n(cnt_n), .len_n(len_n)
  );

  scl_pg_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .run_q(run_q), .ph_q(ph_q),
    .run_n(run_n), .ph_n(ph_n), .cnt_n(cnt_n), .len_n(len_n),
    .scl_q(scl_o), .stb_q(stb_q)
  );

  assign sda_drive_stb  = stb_q.drive;
  assign sda_sample_stb = stb_q.sample;
  assign scl_rise_stb   = stb_q.rise;
  assign scl_fall_stb   = stb_q.fall;
endmodule

// File: rtl/scl_pg_chk.sv
`timescale 1ns/1ps
module scl_pg_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_o,
  input logic sda_drive_stb,
  input logic sda_sample_stb,
  input logic scl_rise_stb,
  input logic scl_fall_stb
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !sda_drive_stb && !sda_sample_stb && !scl_rise_stb && !scl_fall_stb));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sda_drive_stb, sda_sample_stb, scl_rise_stb, scl_fall_stb}));

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (rst)
    scl_rise_stb |-> $rose(scl_o));

  p_fall_edge_r6: assert property (@(posedge clk) disable iff (rst)
    scl_fall_stb |-> $fell(scl_o));

  p_fall_flagged_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> scl_fall_stb);

  p_drive_in_low_r4: assert property (@(posedge clk) disable iff (rst)
    sda_drive_stb |-> !scl_o);

  p_sample_in_high_r5: assert property (@(posedge clk) disable iff (rst)
    sda_sample_stb |-> scl_o);
endmodule

bind scl_phase_gen scl_pg_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .scl_o(scl_o),
  .sda_drive_stb(sda_drive_stb), .sda_sample_stb(sda_sample_stb),
  .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
);

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;
  localparam int UNIT = 8;
  localparam int K_DRIVE = 0, K_SAMPLE = 1, K_RISE = 2, K_FALL = 3;

  typedef struct {
    int kind;
    int idx;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] div_cfg = '0;
  logic        scl_o, sda_drive_stb, sda_sample_stb, scl_rise_stb, scl_fall_stb;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  bit    arm   = 1'b0;
  bit    trk   = 1'b0;
  int    rel   = 0;
  string tag   = "R9";
  ev_t   evq[$];
  bit    exp_scl[$];

  always #4 clk = ~clk;

  scl_phase_gen u0 (
    .clk(clk), .rst(rst), .en(en), .div_cfg(div_cfg),
    .scl_o(scl_o), .sda_drive_stb(sda_drive_stb), .sda_sample_stb(sda_sample_stb),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
  );

  // index 0 is the cycle after the edge that first sees en high
  always @(posedge clk) begin
    if (arm && !trk) begin
      trk <= 1'b1;
      rel <= 0;
    end else if (!arm) begin
      trk <= 1'b0;
    end else begin
      rel <= rel + 1;
    end
  end

  function automatic string kname(input int k);
    case (k)
      K_DRIVE:  return "drive(R4)";
      K_SAMPLE: return "sample(R5)";
      K_RISE:   return "rise(R6)";
      default:  return "fall(R6)";
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      int nstb;
      int kind;
      nstb = int'(sda_drive_stb) + int'(sda_sample_stb) + int'(scl_rise_stb) + int'(scl_fall_stb);
      kind = sda_drive_stb ? K_DRIVE : sda_sample_stb ? K_SAMPLE : scl_rise_stb ? K_RISE : K_FALL;
      if (trk) begin
        n_chk++;
        if (rel < exp_scl.size() && scl_o !== exp_scl[rel]) begin
          n_err++;
          $display("FAIL %s scl level at index %0d: actual=%0b expected=%0b", tag, rel, scl_o, exp_scl[rel]);
        end
        if (nstb > 1) begin
          n_chk++; n_err++;
          $display("FAIL R10 strobes at index %0d: actual=%0d high expected=at most 1", rel, nstb);
        end
        if (nstb >= 1) begin
          n_chk++;
          if (evq.size() == 0) begin
            n_err++;
            $display("FAIL %s unexpected %s at index %0d: actual=strobe expected=none", tag, kname(kind), rel);
          end else begin
            ev_t e;
            e = evq.pop_front();
            if (e.kind != kind || e.idx != rel) begin
              n_err++;
              $display("FAIL %s %s: actual=%s@%0d expected=%s@%0d", tag, kname(e.kind), kname(kind), rel, kname(e.kind), e.idx);
            end
          end
        end else if (evq.size() > 0 && evq[0].idx == rel) begin
          ev_t e;
          e = evq.pop_front();
          n_chk++; n_err++;
          $display("FAIL %s %s missing at index %0d: actual=none expected=strobe", tag, kname(e.kind), rel);
        end
      end else begin
        n_chk++;
        if (scl_o !== 1'b1 || nstb != 0) begin
          n_err++;
          $display("FAIL R9 idle: actual scl=%0b strobes=%0d expected scl=1 strobes=0", scl_o, nstb);
        end
      end
    end
  end

  function automatic int plen(input int f);
    return ((f == 0) ? 1 : f) * UNIT;
  endfunction

  // driver: fills the scoreboard, then applies the stimulus
  task automatic run_case(input string t, input int a_lo, input int a_hi,
                          input int b_lo, input int b_hi, input int chg, input int win);
    int s;
    int k;
    tag = t;
    evq.delete();
    exp_scl.delete();
    s = 0;
    k = 0;
    while (s < win) begin
      int lh;
      int ll;
      lh = plen(k == 0 ? a_hi : b_hi);
      ll = plen(k == 0 ? a_lo : b_lo);
      if (k > 0) evq.push_back('{K_RISE, s});
      if (s + lh/2 - 1 < win) evq.push_back('{K_SAMPLE, s + lh/2 - 1});
      if (s + lh < win) evq.push_back('{K_FALL, s + lh});
      if (s + lh + ll/2 - 1 < win) evq.push_back('{K_DRIVE, s + lh + ll/2 - 1});
      for (int i = 0; i < lh; i++) exp_scl.push_back(1'b1);
      for (int i = 0; i < ll; i++) exp_scl.push_back(1'b0);
      s = s + lh + ll;
      if (s < win) begin
        // next rise lies inside the window only if it is below win
      end
      k++;
    end
    // drop a rise that falls at or beyond the window
    while (evq.size() > 0 && evq[evq.size()-1].idx >= win) void'(evq.pop_back());
    @(negedge clk);
    div_cfg = {16'(a_hi), 16'(a_lo)};
    en  = 1'b1;
    arm = 1'b1;
    if (chg > 0) begin
      repeat (chg) @(negedge clk);
      div_cfg = {16'(b_hi), 16'(b_lo)};
      repeat (win - chg) @(negedge clk);
    end else begin
      repeat (win) @(negedge clk);
    end
    en  = 1'b0;
    arm = 1'b0;
    repeat (6) @(negedge clk);
    n_chk++;
    if (evq.size() != 0) begin
      n_err++;
      $display("FAIL %s pending strobes at end: actual=%0d left expected=0", t, evq.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (scl_o !== 1'b1 || sda_drive_stb || sda_sample_stb || scl_rise_stb || scl_fall_stb) begin
      n_err++;
      $display("FAIL R9 reset state: actual scl=%0b expected scl=1 with no strobes", scl_o);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: asymmetric halves, low 3 units and high 5 units
    run_case("R1", 3, 5, 3, 5, 0, 200);
    // R2: symmetric halves of 2 units
    run_case("R2", 2, 2, 2, 2, 0, 100);
    // R7: zero fields act as one unit
    run_case("R7", 0, 0, 0, 0, 0, 60);
    run_case("R7", 0, 3, 0, 3, 0, 90);
    // R8: divider change during the first low phase (index H+2)
    run_case("R8", 2, 2, 4, 1, 18, 130);
    // R9: disable while SCL is low, then R3: restart begins with a high phase
    run_case("R9", 4, 2, 4, 2, 0, 30);
    run_case("R3", 1, 6, 1, 6, 0, 70);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule